// File: doc/BRIEF.md
# Gated Window BCD Frequency Counter

This block measures the frequency of a digitised signal. It counts the signal's rising edges inside a gate window of fixed length and then hands the result over. Measurement cycles run back to back. Each cycle has three phases. First the window is open and edges are counted. Then the window closes and a capture phase copies the count into an output register. Last comes a clear phase that resets the counter before the next window opens.

All phase lengths are measured in pulses of a `tick` input, which marks one period of an external timebase. Take a tick every 50 µs as an example. A 200-tick window then lasts 10 ms. The capture phase and the clear phase each last one tick, so one full cycle takes 10.1 ms. With three decimal digits, this gives 100 Hz resolution over a 100 kHz full scale.

The captured digits and an overflow flag stay fixed until the next capture. A one-cycle strobe tells a host when a new result is available. The signal input is asynchronous. It is resynchronised into the system clock domain before any edge is detected.

Top module: `gated_freq_counter`

## Requirements
- R1: `result_bcd` holds DIGITS packed BCD digits, units in bits [3:0], tens in [7:4], hundreds in [11:8]. Each digit is always in 0..9. The value equals the number of signal rising edges counted during the last window, when that number is below 10^DIGITS.
- R2: Only rising edges whose synchronised form arrives while the window is open are counted. Edges during the capture and clear phases are never counted.
- R3: Once the count reaches all nines, any further edge leaves the digits at all nines and sets an overflow flag. That flag is captured into `result_ovf` together with the digits, and `result_ovf` high implies `result_bcd` is all nines.
- R4: The counter clear is asserted only after a capture phase, and never in the same cycle as count enable.
- R5: Every window starts from a count of zero, so each result covers a single window only.
- R6: `result_bcd` and `result_ovf` change only in the cycle that follows a capture. They stay stable while the next window is counting.
- R7: `result_valid` is a single-cycle pulse, issued once per window. It rises in the same cycle as the updated result.
- R8: `sig_in` passes through a SYNC_STAGES-flop synchronizer and a rising-edge detector. A level held high across a whole window counts nothing, and each low-to-high transition counts exactly once.
- R9: While `rst_n` is low, `result_bcd`, `result_ovf` and `result_valid` are all zero. After reset is released, a new window opens at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Asynchronous digitised signal to be measured |
| tick | input | 1 | One-cycle pulse per timebase period |
| result_bcd | output | 4*DIGITS | Latched BCD count, units digit lowest |
| result_ovf | output | 1 | Latched overflow flag of the last window |
| result_valid | output | 1 | One-cycle strobe when a new result is latched |

## Verification
The assertions assume three things about the inputs. `tick` is a single-cycle pulse. `sig_in` stays at each level for at least one full clock cycle, so every transition survives the synchronizer and no two detected edges fall in adjacent cycles. Ticks are spaced far enough apart that each phase spans many clocks.

The stimulus respects all of this. It drives the signal on falling clock edges, with levels held for at least one cycle, and it issues a tick every 600 clocks. It also times its pulse bursts from the valid strobe. Counted bursts therefore fall wholly inside a window, and the deliberately uncounted bursts fall wholly inside the capture phase.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
   typedef enum logic [1:0] {
      PH_WINDOW  = 2'd0,
      PH_CAPTURE = 2'd1,
      PH_CLEAR   = 2'd2
   } phase_t;
endpackage

// File: rtl/gfc_sync_edge.sv
module gfc_sync_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_pulse
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("gfc_sync_edge: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
         prev_q  <= chain_q[SYNC_STAGES-1];
      end
   end

   assign rise_pulse = chain_q[SYNC_STAGES-1] & ~prev_q;

   // R8: a detected edge lasts one cycle, never two in a row
   p_single_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/gfc_phase_seq.sv
module gfc_phase_seq
   import gfc_pkg::*;
#(
   parameter int WINDOW_TICKS  = 200,
   parameter int CAPTURE_TICKS = 1,
   parameter int CLEAR_TICKS   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic cnt_en,
   output logic cap_go,
   output logic clr_en
);
   localparam int MAX_A = (WINDOW_TICKS > CAPTURE_TICKS) ? WINDOW_TICKS : CAPTURE_TICKS;
   localparam int MAX_T = (MAX_A > CLEAR_TICKS) ? MAX_A : CLEAR_TICKS;
   localparam int TW    = $clog2(MAX_T + 1);

   if (WINDOW_TICKS < 1 || CAPTURE_TICKS < 1 || CLEAR_TICKS < 1) begin : g_bad_ticks
      $error("gfc_phase_seq: every phase needs at least one tick");
   end

   phase_t        phase_q;
   logic [TW-1:0] tcnt_q;
   logic [TW-1:0] limit;
   logic          last_tick;

   always_comb begin
      case (phase_q)
         PH_WINDOW:  limit = TW'(WINDOW_TICKS - 1);
         PH_CAPTURE: limit = TW'(CAPTURE_TICKS - 1);
         default:    limit = TW'(CLEAR_TICKS - 1);
      endcase
   end

   assign last_tick = tick && (tcnt_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_WINDOW;
         tcnt_q  <= '0;
         cap_go  <= 1'b0;
      end else begin
         cap_go <= 1'b0;
         if (last_tick) begin
            tcnt_q <= '0;
            case (phase_q)
               PH_WINDOW: begin
                  phase_q <= PH_CAPTURE;
                  cap_go  <= 1'b1;
               end
               PH_CAPTURE: phase_q <= PH_CLEAR;
               default:    phase_q <= PH_WINDOW;
            endcase
         end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
         end
      end
   end

   assign cnt_en = (phase_q == PH_WINDOW);
   assign clr_en = (phase_q == PH_CLEAR);

   // R4: clear is entered only from the capture phase
   p_clear_after_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clr_en) |-> $past(phase_q) == PH_CAPTURE);
   // R7: capture request is a single pulse
   p_cap_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_go |=> !cap_go);
   // R2: the capture pulse follows the window closing
   p_cap_after_win_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_go |-> !cnt_en && $past(cnt_en));
endmodule

// File: rtl/gfc_bcd_counter.sv
module gfc_bcd_counter #(
   parameter int DIGITS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   output logic [4*DIGITS-1:0] count,
   output logic              ovf
);
   if (DIGITS < 1) begin : g_bad_digits
      $error("gfc_bcd_counter: DIGITS must be at least 1");
   end

   logic [DIGITS:0]   run_en;
   logic [DIGITS-1:0] is_nine;
   logic              saturate;

   assign run_en[0] = inc;
   assign saturate  = run_en[DIGITS];

   for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      logic [3:0] dig_q;
      assign is_nine[i]     = (dig_q == 4'd9);
      assign run_en[i+1]    = run_en[i] & is_nine[i];
      assign count[4*i +: 4] = dig_q;

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            dig_q <= 4'd0;
         end else if (run_en[i] && !saturate) begin
            dig_q <= is_nine[i] ? 4'd0 : dig_q + 4'd1;
         end
      end

      // R1: each digit stays a legal decimal value
      p_digit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
         dig_q <= 4'd9);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         ovf <= 1'b0;
      end else if (saturate) begin
         ovf <= 1'b1;
      end
   end

   // R3: at saturation the digits hold
   p_hold_at_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> $stable(count));
endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter #(
   parameter int DIGITS        = 3,
   parameter int SYNC_STAGES   = 2,
   parameter int WINDOW_TICKS  = 200,
   parameter int CAPTURE_TICKS = 1,
   parameter int CLEAR_TICKS   = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sig_in,
   input  logic                tick,
   output logic [4*DIGITS-1:0] result_bcd,
   output logic                result_ovf,
   output logic                result_valid
);
   localparam int                 RW       = 4 * DIGITS;
   localparam logic [RW-1:0]      ALL_NINE = {DIGITS{4'h9}};

   logic          edge_p;
   logic          cnt_en;
   logic          cap_go;
   logic          clr_en;
   logic [RW-1:0] live_cnt;
   logic          live_ovf;

   gfc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (sig_in),
      .rise_pulse (edge_p)
   );

   gfc_phase_seq #(
      .WINDOW_TICKS  (WINDOW_TICKS),
      .CAPTURE_TICKS (CAPTURE_TICKS),
      .CLEAR_TICKS   (CLEAR_TICKS)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .cnt_en (cnt_en),
      .cap_go (cap_go),
      .clr_en (clr_en)
   );

   gfc_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_en),
      .inc   (edge_p & cnt_en),
      .count (live_cnt),
      .ovf   (live_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_bcd   <= '0;
         result_ovf   <= 1'b0;
         result_valid <= 1'b0;
      end else begin
         result_valid <= cap_go;
         if (cap_go) begin
            result_bcd <= live_cnt;
            result_ovf <= live_ovf;
         end
      end
   end

   // R4: clear and count enable never overlap
   p_clr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> !cnt_en);
   // R5: every window opens with an empty counter
   p_zero_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnt_en) |-> (live_cnt == '0 && !live_ovf));
   // R6: the latched result only moves after a capture
   p_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_go |=> $stable(result_bcd) && $stable(result_ovf));
   // R7: valid follows every capture request
   p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_go |=> result_valid);
   // R3: overflow implies saturated digits
   p_ovf_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      result_ovf |-> result_bcd == ALL_NINE);
endmodule

// File: tb/gated_freq_counter_tb_top.sv
module gated_freq_counter_tb_top;
   localparam int TICK_DIV = 600;
   localparam int NVEC     = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sig_in = 1'b0;
   logic        tick = 1'b0;
   logic [11:0] result_bcd;
   logic        result_ovf;
   logic        result_valid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gated_freq_counter #(
      .DIGITS(3), .SYNC_STAGES(2),
      .WINDOW_TICKS(8), .CAPTURE_TICKS(1), .CLEAR_TICKS(1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .tick(tick),
      .result_bcd(result_bcd), .result_ovf(result_ovf), .result_valid(result_valid)
   );

   // timebase: one tick every TICK_DIV clocks
   initial begin
      forever begin
         repeat (TICK_DIV - 1) @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   end

   // {pulses in window, half period, pulses outside window, hold high, exp bcd, exp ovf}
   typedef struct packed {
      logic [10:0] n;
      logic [3:0]  hp;
      logic [5:0]  pre;
      logic        hold;
      logic [11:0] exp_bcd;
      logic        exp_ovf;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{11'd0,    4'd2, 6'd0,  1'b0, 12'h000, 1'b0},
      '{11'd1,    4'd2, 6'd0,  1'b0, 12'h001, 1'b0},
      '{11'd9,    4'd3, 6'd0,  1'b0, 12'h009, 1'b0},
      '{11'd10,   4'd2, 6'd0,  1'b0, 12'h010, 1'b0},
      '{11'd99,   4'd5, 6'd0,  1'b0, 12'h099, 1'b0},
      '{11'd100,  4'd1, 6'd0,  1'b0, 12'h100, 1'b0},
      '{11'd999,  4'd1, 6'd0,  1'b0, 12'h999, 1'b0},
      '{11'd1000, 4'd1, 6'd0,  1'b0, 12'h999, 1'b1},
      '{11'd1005, 4'd2, 6'd0,  1'b0, 12'h999, 1'b1},
      '{11'd37,   4'd7, 6'd5,  1'b0, 12'h037, 1'b0},
      '{11'd0,    4'd2, 6'd20, 1'b0, 12'h000, 1'b0},
      '{11'd0,    4'd2, 6'd0,  1'b1, 12'h000, 1'b0},
      '{11'd505,  4'd3, 6'd0,  1'b0, 12'h505, 1'b0}
   };

   task automatic check(input bit ok, input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulses(input int n, input int hp);
      for (int k = 0; k < n; k++) begin
         sig_in = 1'b1;
         repeat (hp) @(negedge clk);
         sig_in = 1'b0;
         repeat (hp) @(negedge clk);
      end
   endtask

   // wait for the next strobe; the held result must not move meanwhile (R6)
   task automatic wait_valid();
      logic [12:0] snap;
      bit moved;
      snap = {result_ovf, result_bcd};
      moved = 1'b0;
      @(negedge clk);
      while (!result_valid) begin
         if ({result_ovf, result_bcd} != snap) moved = 1'b1;
         @(negedge clk);
      end
      check(!moved, "R6 result stable between captures", 16'(moved), 16'd0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R9: reset state
      check(result_bcd == 12'h000 && !result_ovf && !result_valid, "R9 reset",
            {3'd0, result_valid, result_ovf, result_bcd}, 16'd0);
      rst_n = 1'b1;
      wait_valid();
      // R5: first window after reset sees no edges
      check(result_bcd == 12'h000 && !result_ovf, "R5 empty first window",
            {3'd0, result_ovf, result_bcd}, 16'd0);

      foreach (VECS[v]) begin
         @(negedge clk);
         // R7: strobe lasts one cycle
         check(!result_valid, "R7 valid single cycle", 16'(result_valid), 16'd0);
         sig_in = 1'b0;
         // pulses during capture phase must not count (R2)
         pulses(int'(VECS[v].pre), 2);
         if (VECS[v].hold) sig_in = 1'b1;   // R8: rise outside window, held high
         repeat (1300 - 1 - 4 * int'(VECS[v].pre)) @(negedge clk);
         pulses(int'(VECS[v].n), int'(VECS[v].hp));
         wait_valid();
         // R1 count, R2 gating, R3 overflow, R8 held level
         check(result_bcd == VECS[v].exp_bcd && result_ovf == VECS[v].exp_ovf,
               "R1 R2 R3 R8 latched count",
               {3'd0, result_ovf, result_bcd}, {3'd0, VECS[v].exp_ovf, VECS[v].exp_bcd});
         sig_in = 1'b0;
      end

      // R9: reset in mid-run clears a nonzero result
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(result_bcd == 12'h000 && !result_ovf && !result_valid, "R9 mid-run reset",
            {3'd0, result_valid, result_ovf, result_bcd}, 16'd0);
      rst_n = 1'b1;
      // R5: window opens at once after reset; a burst inside it counts from zero
      repeat (100) @(negedge clk);
      pulses(12, 2);
      wait_valid();
      check(result_bcd == 12'h012 && !result_ovf, "R5 count after reset",
            {3'd0, result_ovf, result_bcd}, 16'h0012);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   // watchdog
   initial begin
      repeat (190000) @(negedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule